// File: doc/BRIEF.md
# ASID-Tagged Page Mapping MMU

This block translates addresses for a small in-order core. It works in two steps. First, each virtual offset from a request is compared against a bound register. If it is in range, a base register is added to it. Second, the relocated address is split into a 1 KB page offset and a virtual page number. The page number, joined with the address space identifier held in the translation control word, selects one entry of an internal mapping table. That entry holds a 9-bit physical page number. The physical page number and the page offset together form the physical address. There is no table walk in memory, because the table lives inside the block. Translation runs in every privilege level.

The translation control word uses a custom encoding. The top mode bit must be clear and the two upper identifier bits must both be set. The low bits of the word do not point at memory; they hold the log2 of the number of pages each address space may use. The table is rewritten one entry at a time by a swap operation, which writes a new page number and returns the old one. Before a swap may commit, the core's count of outstanding memory operations must fall to zero. While a swap is in flight, new translations are held off.

Top module: `pgmap_mmu`

## Requirements
- R1: A request is translated only when satp[31]=0 and satp[30:29]=2'b11. Any other satp value gives fault cause 2 (mode). This cause takes priority over every other cause.
- R2: A request offset that is at or above the bound, compared zero-extended to 38 bits, gives fault cause 1 (bound). This cause takes priority over cause 3.
- R3: The relocated address is base plus offset. The table index is {satp[26:22], reloc[15:10]}. The result address is {entry, reloc[9:0]}.
- R4: The size code satp[4:0], clamped to 6, gives the page limit 2^code. A page number at or above this limit gives fault cause 3 (range). Any set relocated bit above bit 15 also gives cause 3.
- R5: The fault flag is high exactly when the cause is nonzero. A faulting response carries an address of zero.
- R6: A request accepted at one clock edge (valid and ready both high) produces a response valid for exactly the following cycle. Otherwise the response is not valid.
- R7: A swap does not commit while the outstanding-operation count is nonzero. Swap done is a single-cycle pulse.
- R8: A swap returns the previous page number of the chosen entry and stores the new one. Lookups that follow see the new value.
- R9: Request ready is low from the cycle after a swap is accepted until the done pulse has ended. Requests made during that time produce no response.
- R10: Entries of different address spaces with the same page number are independent.
- R11: After reset, response valid and swap done are low and request ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Translation request |
| req_va_i | input | 32 | Virtual offset |
| req_ready_o | output | 1 | Request can be accepted |
| satp_i | input | 32 | Translation control word |
| base_i | input | 38 | Relocation base |
| bound_i | input | 38 | Offset limit |
| rsp_valid_o | output | 1 | Response valid |
| rsp_pa_o | output | 19 | Physical address |
| rsp_fault_o | output | 1 | Request faulted |
| rsp_cause_o | output | 2 | 0 none, 1 bound, 2 mode, 3 range |
| swap_req_i | input | 1 | Start a table swap |
| swap_idx_i | input | 11 | Entry index {asid, vpn} |
| swap_ppn_i | input | 9 | New page number |
| mem_pending_i | input | 4 | Outstanding memory operations |
| swap_done_o | output | 1 | Swap committed |
| swap_old_o | output | 9 | Previous page number |

## Verification
Several properties are checked on every cycle:
- a response follows only an accepted request;
- a faulting response always carries a zero address;
- a done pulse follows only a cycle with no outstanding operations, and never lasts two cycles;
- an accepted swap always takes the block out of idle.

Other behaviour can only be shown by the bench's scenarios:
- the decode of the satp encodings;
- the order of priority between fault causes;
- the page-limit arithmetic;
- that swaps return old values and lookups see new ones;
- that address spaces stay separate.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
    localparam int unsigned PG_OFF_W = 10;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_BOUND = 2'd1,
        CAUSE_MODE  = 2'd2,
        CAUSE_RANGE = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        SW_IDLE  = 2'd0,
        SW_DRAIN = 2'd1,
        SW_DONE  = 2'd2
    } swst_e;
endpackage

// File: rtl/mmu_satp_dec.sv
module mmu_satp_dec #(
    parameter int unsigned ASID_W = 5,
    parameter int unsigned VPN_W  = 6,
    localparam int unsigned LIM_W = $clog2(VPN_W + 1)
) (
    input  logic [31:0]       satp_i,
    output logic              custom_o,
    output logic [ASID_W-1:0] asid_o,
    output logic [LIM_W-1:0]  lim_log2_o
);
    logic       mode_bit;
    logic [1:0] asid_top;
    logic [4:0] size_code;

    always_comb begin
        mode_bit  = satp_i[31];
        asid_top  = satp_i[30:29];
        size_code = satp_i[4:0];
        custom_o  = !mode_bit && (asid_top == 2'b11);
        asid_o    = satp_i[22 +: ASID_W];
        if (32'(size_code) >= VPN_W) begin
            lim_log2_o = LIM_W'(VPN_W);
        end else begin
            lim_log2_o = LIM_W'(size_code);
        end
    end
endmodule

// File: rtl/mmu_bounds.sv
module mmu_bounds #(
    parameter int unsigned VA_W = 32,
    parameter int unsigned RA_W = 38
) (
    input  logic [VA_W-1:0] va_i,
    input  logic [RA_W-1:0] base_i,
    input  logic [RA_W-1:0] bound_i,
    output logic [RA_W-1:0] reloc_o,
    output logic            over_o
);
    logic [RA_W-1:0] va_ext;

    always_comb begin
        va_ext  = RA_W'(va_i);
        over_o  = (va_ext >= bound_i);
        reloc_o = base_i + va_ext;
    end
endmodule

// File: rtl/mmu_page_chk.sv
module mmu_page_chk #(
    parameter int unsigned RA_W  = 38,
    parameter int unsigned VPN_W = 6,
    localparam int unsigned OFF_W = mmu_pkg::PG_OFF_W,
    localparam int unsigned LIM_W = $clog2(VPN_W + 1),
    localparam int unsigned TOP_W = OFF_W + VPN_W
) (
    input  logic [RA_W-1:0]  reloc_i,
    input  logic [LIM_W-1:0] lim_log2_i,
    output logic [VPN_W-1:0] vpn_o,
    output logic [OFF_W-1:0] off_o,
    output logic             range_err_o
);
    logic high_set;

    generate
        if (RA_W > TOP_W) begin : g_high
            assign high_set = |reloc_i[RA_W-1:TOP_W];
        end else begin : g_nohigh
            assign high_set = 1'b0;
        end
    endgenerate

    always_comb begin
        vpn_o       = reloc_i[OFF_W +: VPN_W];
        off_o       = reloc_i[OFF_W-1:0];
        range_err_o = high_set || ((vpn_o >> lim_log2_i) != '0);
    end
endmodule

// File: rtl/mmu_swap_ctl.sv
module mmu_swap_ctl #(
    parameter int unsigned IDX_W = 11,
    parameter int unsigned PPN_W = 9,
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             swap_req_i,
    input  logic [IDX_W-1:0] swap_idx_i,
    input  logic [PPN_W-1:0] swap_ppn_i,
    input  logic [CNT_W-1:0] pending_i,
    output logic             we_o,
    output logic [IDX_W-1:0] widx_o,
    output logic [PPN_W-1:0] wdata_o,
    output logic             idle_o,
    output logic             done_o
);
    import mmu_pkg::*;

    typedef struct packed {
        swst_e            st;
        logic [IDX_W-1:0] idx;
        logic [PPN_W-1:0] ppn;
    } sw_t;

    sw_t sw_d, sw_q;

    always_comb begin
        sw_d = sw_q;
        we_o = 1'b0;
        unique case (sw_q.st)
            SW_IDLE: begin
                if (swap_req_i) begin
                    sw_d.st  = SW_DRAIN;
                    sw_d.idx = swap_idx_i;
                    sw_d.ppn = swap_ppn_i;
                end
            end
            SW_DRAIN: begin
                if (pending_i == '0) begin
                    we_o    = 1'b1;
                    sw_d.st = SW_DONE;
                end
            end
            SW_DONE:  sw_d.st = SW_IDLE;
            default:  sw_d.st = SW_IDLE;
        endcase
        widx_o  = sw_q.idx;
        wdata_o = sw_q.ppn;
        idle_o  = (sw_q.st == SW_IDLE);
        done_o  = (sw_q.st == SW_DONE);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sw_q <= '{st: SW_IDLE, idx: '0, ppn: '0};
        end else begin
            sw_q <= sw_d;
        end
    end

    // R7
    single_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R9
    swap_leaves_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (swap_req_i && idle_o) |=> !idle_o);
endmodule

// File: rtl/mmu_map_table.sv
module mmu_map_table #(
    parameter int unsigned IDX_W = 11,
    parameter int unsigned PPN_W = 9,
    localparam int unsigned DEPTH = 1 << IDX_W
) (
    input  logic             clk_i,
    input  logic             re_i,
    input  logic [IDX_W-1:0] raddr_i,
    input  logic             we_i,
    input  logic [IDX_W-1:0] waddr_i,
    input  logic [PPN_W-1:0] wdata_i,
    output logic [PPN_W-1:0] rdata_q
);
    logic [PPN_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (re_i) begin
            rdata_q <= mem_q[raddr_i];
        end
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end
endmodule

// File: rtl/pgmap_mmu.sv
module pgmap_mmu #(
    parameter int unsigned VA_W   = 32,
    parameter int unsigned RA_W   = 38,
    parameter int unsigned ASID_W = 5,
    parameter int unsigned VPN_W  = 6,
    parameter int unsigned PPN_W  = 9,
    parameter int unsigned CNT_W  = 4,
    localparam int unsigned OFF_W = mmu_pkg::PG_OFF_W,
    localparam int unsigned IDX_W = ASID_W + VPN_W,
    localparam int unsigned PA_W  = PPN_W + OFF_W,
    localparam int unsigned LIM_W = $clog2(VPN_W + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_valid_i,
    input  logic [VA_W-1:0]  req_va_i,
    output logic             req_ready_o,
    input  logic [31:0]      satp_i,
    input  logic [RA_W-1:0]  base_i,
    input  logic [RA_W-1:0]  bound_i,
    output logic             rsp_valid_o,
    output logic [PA_W-1:0]  rsp_pa_o,
    output logic             rsp_fault_o,
    output logic [1:0]       rsp_cause_o,
    input  logic             swap_req_i,
    input  logic [IDX_W-1:0] swap_idx_i,
    input  logic [PPN_W-1:0] swap_ppn_i,
    input  logic [CNT_W-1:0] mem_pending_i,
    output logic             swap_done_o,
    output logic [PPN_W-1:0] swap_old_o
);
    import mmu_pkg::*;

    typedef struct packed {
        logic             vld;
        cause_e           cause;
        logic [OFF_W-1:0] off;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic              custom;
    logic [ASID_W-1:0] asid;
    logic [LIM_W-1:0]  lim_log2;
    logic [RA_W-1:0]   reloc;
    logic              over;
    logic [VPN_W-1:0]  vpn;
    logic [OFF_W-1:0]  off;
    logic              range_err;
    logic              sw_we, sw_idle;
    logic [IDX_W-1:0]  sw_idx;
    logic [PPN_W-1:0]  sw_ppn;
    logic [PPN_W-1:0]  tbl_rd;
    logic              accept;
    logic              tbl_re;
    logic [IDX_W-1:0]  tbl_raddr;

    mmu_satp_dec #(.ASID_W(ASID_W), .VPN_W(VPN_W)) i_dec (
        .satp_i     (satp_i),
        .custom_o   (custom),
        .asid_o     (asid),
        .lim_log2_o (lim_log2)
    );

    mmu_bounds #(.VA_W(VA_W), .RA_W(RA_W)) i_bounds (
        .va_i    (req_va_i),
        .base_i  (base_i),
        .bound_i (bound_i),
        .reloc_o (reloc),
        .over_o  (over)
    );

    mmu_page_chk #(.RA_W(RA_W), .VPN_W(VPN_W)) i_page (
        .reloc_i     (reloc),
        .lim_log2_i  (lim_log2),
        .vpn_o       (vpn),
        .off_o       (off),
        .range_err_o (range_err)
    );

    mmu_swap_ctl #(.IDX_W(IDX_W), .PPN_W(PPN_W), .CNT_W(CNT_W)) i_swap (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .swap_req_i (swap_req_i),
        .swap_idx_i (swap_idx_i),
        .swap_ppn_i (swap_ppn_i),
        .pending_i  (mem_pending_i),
        .we_o       (sw_we),
        .widx_o     (sw_idx),
        .wdata_o    (sw_ppn),
        .idle_o     (sw_idle),
        .done_o     (swap_done_o)
    );

    mmu_map_table #(.IDX_W(IDX_W), .PPN_W(PPN_W)) i_table (
        .clk_i   (clk_i),
        .re_i    (tbl_re),
        .raddr_i (tbl_raddr),
        .we_i    (sw_we),
        .waddr_i (sw_idx),
        .wdata_i (sw_ppn),
        .rdata_q (tbl_rd)
    );

    always_comb begin
        rsp_d       = rsp_q;
        req_ready_o = sw_idle;
        accept      = req_valid_i && sw_idle;
        tbl_re      = accept || sw_we;
        tbl_raddr   = sw_we ? sw_idx : {asid, vpn};
        rsp_d.vld   = accept;
        if (accept) begin
            rsp_d.off = off;
            if (!custom) begin
                rsp_d.cause = CAUSE_MODE;
            end else if (over) begin
                rsp_d.cause = CAUSE_BOUND;
            end else if (range_err) begin
                rsp_d.cause = CAUSE_RANGE;
            end else begin
                rsp_d.cause = CAUSE_NONE;
            end
        end
        rsp_valid_o = rsp_q.vld;
        rsp_cause_o = rsp_q.cause;
        rsp_fault_o = (rsp_q.cause != CAUSE_NONE);
        rsp_pa_o    = (rsp_q.cause == CAUSE_NONE) ? {tbl_rd, rsp_q.off} : '0;
        swap_old_o  = tbl_rd;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rsp_q <= '{vld: 1'b0, cause: CAUSE_NONE, off: '0};
        end else begin
            rsp_q <= rsp_d;
        end
    end

    // R6
    rsp_follows_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |-> $past(req_valid_i && req_ready_o));

    // R5
    fault_zero_pa_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && rsp_fault_o) |-> (rsp_pa_o == '0));

    // R7
    drain_before_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(swap_done_o) |-> $past(mem_pending_i == '0));

    // R9
    no_rsp_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!req_ready_o) |=> !rsp_valid_o);
endmodule

// File: tb/test_pgmap_mmu.sv
module test_pgmap_mmu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic        req_ready;
    logic [31:0] satp = '0;
    logic [37:0] base = 38'h400;
    logic [37:0] bound = 38'h2000;
    logic        rsp_valid;
    logic [18:0] rsp_pa;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;
    logic        swap_req = 1'b0;
    logic [10:0] swap_idx = '0;
    logic [8:0]  swap_ppn = '0;
    logic [3:0]  pending = '0;
    logic        swap_done;
    logic [8:0]  swap_old;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pgmap_mmu i_pgmap_mmu (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_va_i(req_va), .req_ready_o(req_ready),
        .satp_i(satp), .base_i(base), .bound_i(bound),
        .rsp_valid_o(rsp_valid), .rsp_pa_o(rsp_pa),
        .rsp_fault_o(rsp_fault), .rsp_cause_o(rsp_cause),
        .swap_req_i(swap_req), .swap_idx_i(swap_idx), .swap_ppn_i(swap_ppn),
        .mem_pending_i(pending), .swap_done_o(swap_done), .swap_old_o(swap_old)
    );

    typedef struct packed {
        logic [31:0] satp;
        logic [31:0] va;
        logic [1:0]  cause;
        logic [18:0] pa;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{32'h60C00003, 32'h0004, 2'd0, 19'h68C04},  // R3 page 1
        '{32'h60C00003, 32'h13FF, 2'd0, 19'h3FFFF},  // R3 page 5
        '{32'h60C00003, 32'h1FFF, 2'd3, 19'h0},      // R4 page 8 over limit
        '{32'h60C00003, 32'h2000, 2'd1, 19'h0},      // R2 at bound
        '{32'h00C00003, 32'h0004, 2'd2, 19'h0},      // R1 id top bits clear
        '{32'hE0C00003, 32'h0004, 2'd2, 19'h0},      // R1 mode bit set
        '{32'h00000000, 32'h3000, 2'd2, 19'h0},      // R1 priority over bound
        '{32'h60C00003, 32'h2400, 2'd1, 19'h0},      // R2 priority over range
        '{32'h6100000F, 32'h0004, 2'd0, 19'h1DC04}   // R10 other space page 1
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic lookup(input logic [31:0] s, input logic [31:0] va,
                          input string req, input logic [1:0] ec, input logic [18:0] ep);
        @(negedge clk);
        satp = s; req_va = va; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, 32'(rsp_valid), 32'd1);
        check({req, " cause"}, 32'(rsp_cause), 32'(ec));
        check({req, " fault"}, 32'(rsp_fault), 32'(ec != 2'd0));
        check({req, " pa"}, 32'(rsp_pa), 32'(ep));
    endtask

    task automatic do_swap(input logic [10:0] idx, input logic [8:0] ppn,
                           output logic [8:0] old);
        @(negedge clk);
        swap_req = 1'b1; swap_idx = idx; swap_ppn = ppn;
        @(negedge clk);
        swap_req = 1'b0;
        for (int k = 0; k < 50 && !swap_done; k++) @(negedge clk);
        old = swap_old;
        check("R7 swap completes", 32'(swap_done), 32'd1);
    endtask

    initial begin
        logic [8:0] old;
        repeat (3) @(negedge clk);
        // R11
        check("R11 rsp_valid", 32'(rsp_valid), 32'd0);
        check("R11 swap_done", 32'(swap_done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 ready", 32'(req_ready), 32'd1);

        do_swap(11'h0C1, 9'h1A3, old);
        do_swap(11'h0C5, 9'h0FF, old);
        do_swap(11'h101, 9'h077, old);
        @(negedge clk);
        check("R7 done is a pulse", 32'(swap_done), 32'd0);

        for (int i = 0; i < NV; i++) begin
            lookup(VEC[i].satp, VEC[i].va, $sformatf("vec%0d", i), VEC[i].cause, VEC[i].pa);
        end

        // R6: no request, no response
        @(negedge clk);
        check("R6 idle no response", 32'(rsp_valid), 32'd0);

        // R4: relocated bits above the table range
        bound = 38'h40000;
        lookup(32'h6100000F, 32'h10000, "R4 high bits", 2'd3, 19'h0);
        bound = 38'h2000;

        // R7 and R9: swap held off by outstanding operations
        pending = 4'd3;
        @(negedge clk);
        swap_req = 1'b1; swap_idx = 11'h0C5; swap_ppn = 9'h100;
        @(negedge clk);
        swap_req = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 held while pending", 32'(swap_done), 32'd0);
        check("R9 ready low", 32'(req_ready), 32'd0);
        satp = 32'h60C00003; req_va = 32'h13FF; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 request ignored", 32'(rsp_valid), 32'd0);
        pending = 4'd0;
        for (int k = 0; k < 20 && !swap_done; k++) @(negedge clk);
        check("R7 done after drain", 32'(swap_done), 32'd1);
        check("R9 ready low at done", 32'(req_ready), 32'd0);
        // R8
        check("R8 old value", 32'(swap_old), 32'h0FF);
        @(negedge clk);
        check("R9 ready back", 32'(req_ready), 32'd1);
        lookup(32'h60C00003, 32'h13FF, "R8 new value", 2'd0, 19'h403FF);
        do_swap(11'h0C5, 9'h0AA, old);
        check("R8 second old value", 32'(old), 32'h100);
        // R10: other space untouched
        lookup(32'h6100000F, 32'h0004, "R10 untouched", 2'd0, 19'h1DC04);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule